// File: doc/BRIEF.md
# Severity-Prioritized Error Record Logger

This block holds one error record for a hardware unit that detects faults. Each cycle the unit may present one error report on a strobe. The report carries severity bits, a priority, an error code, an address-type code and four qualifier flags. The logger decides whether the report replaces the stored record or is only folded into it.

Three severity levels exist. From most to least severe they are uncorrected-unsignaled (UUE), uncorrected-deferred (UDE) and corrected (CE). A more severe report always takes over the record. A report of the same severity takes over only when its priority is strictly higher. A less severe report leaves the record untouched.

Alongside the record the block keeps:
- sticky severity history bits;
- a multiple-occurrence flag;
- a read-in-progress flag, which marks a record that no later error has disturbed;
- a corrected-error counter with a sticky overflow flag.

Software clears the valid bit through a control write. Every status field is a register, and each update is visible one clock after the edge that samples the inputs.

Top module: `err_rec_logger`

## Requirements
- R1: While `rst` is high at a clock edge, every status output, including the counter and the overflow flag, becomes 0.
- R2: A report's severity is taken from its highest set bit, ordered UUE > UDE > CE. A strobe with no severity bit set changes no status output.
- R3: A report that arrives while the record is not valid is logged one clock later. The valid bit is set and `st_rdip` is 1. `st_mo` is 0. The sticky bits take the report's highest severity bit alone, with lower bits masked off. Priority, code, address type and the four flags are copied from the report.
- R4: A report more severe than the stored record, while valid, OR-s its severity bits into the sticky bits. It clears `st_rdip`, replaces priority, code, address type and flags, and leaves `st_mo` unchanged.
- R5: A report of equal severity, while valid, sets `st_mo` and clears `st_rdip`. It replaces priority, code, address type and flags only if its priority is strictly greater than `st_pri`.
- R6: A report less severe than the stored record, while valid, changes no status output other than the CE counter.
- R7: Every strobe with `ev_ce` set increments `st_cec`. An increment from all ones wraps to 0 and sets `st_ceco`, which then stays 1 until reset.
- R8: A control write (`ctl_we` high) with `ctl_inval` at 1 clears `st_valid` and leaves the other record fields unchanged.
- R9: When an invalidate and a report arrive in the same cycle, the invalidate applies first, so the report is logged as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | New error report strobe |
| ev_uue | input | 1 | Report severity: uncorrected-unsignaled |
| ev_ude | input | 1 | Report severity: uncorrected-deferred |
| ev_ce | input | 1 | Report severity: corrected |
| ev_pri | input | PRI_W | Report priority |
| ev_code | input | CODE_W | Report error code |
| ev_atype | input | AT_W | Report address-type code |
| ev_info_vld | input | 1 | Report carries information |
| ev_supp_vld | input | 1 | Report carries supplemental information |
| ev_ts_vld | input | 1 | Report carries a timestamp |
| ev_scrub | input | 1 | Report came from a scrub |
| ctl_we | input | 1 | Control register write strobe |
| ctl_inval | input | 1 | Control write data: invalidate the record |
| st_valid | output | 1 | Record valid |
| st_uue | output | 1 | Sticky UUE history |
| st_ude | output | 1 | Sticky UDE history |
| st_ce | output | 1 | Sticky CE history |
| st_mo | output | 1 | Multiple occurrence |
| st_rdip | output | 1 | Read in progress |
| st_pri | output | PRI_W | Stored priority |
| st_code | output | CODE_W | Stored error code |
| st_atype | output | AT_W | Stored address type |
| st_info_vld | output | 1 | Stored information-valid flag |
| st_supp_vld | output | 1 | Stored supplemental-valid flag |
| st_ts_vld | output | 1 | Stored timestamp-valid flag |
| st_scrub | output | 1 | Stored scrub flag |
| st_cec | output | CEC_W | Corrected-error count |
| st_ceco | output | 1 | Sticky counter overflow |

## Verification
The bench targets five corner cases, each paired with the failure it would expose:
- **Priority ties.** An equal-priority report of equal severity is sent. A design that used greater-or-equal would overwrite the code here.
- **Multi-bit first report.** A first report carries all three severity bits. A design without masking would store CE and UDE history that never occurred.
- **Invalidate colliding with a report.** Both arrive in the same cycle. A design that ordered them wrongly would merge the report into a stale record, or would leave `st_rdip` cleared.
- **Counter wraparound.** The counter is driven through a wrap and then past it. A non-sticky overflow flag would drop back to 0 on the next increment.
- **Less severe report.** A lower-severity CE still counts while the record stays untouched. This catches a design that skipped the count or disturbed the record.

// File: rtl/err_rec_pkg.sv
package err_rec_pkg;

  typedef enum logic [1:0] {
    SEV_NONE = 2'd0,
    SEV_CE   = 2'd1,
    SEV_UDE  = 2'd2,
    SEV_UUE  = 2'd3
  } sev_e;

  typedef enum logic [1:0] {
    ACT_IGNORE = 2'd0,
    ACT_FIRST  = 2'd1,
    ACT_RAISE  = 2'd2,
    ACT_SAME   = 2'd3
  } act_e;

  // Highest set bit wins: UUE above UDE above CE.
  function automatic sev_e sev_of(input logic u, input logic d, input logic c);
    if (u)      return SEV_UUE;
    else if (d) return SEV_UDE;
    else if (c) return SEV_CE;
    else        return SEV_NONE;
  endfunction

endpackage

// File: rtl/err_rec_decide.sv
module err_rec_decide
  import err_rec_pkg::*;
#(
  parameter int PRI_W = 2
) (
  input  logic             ev_valid,
  input  logic             rec_live,
  input  sev_e             new_sev,
  input  sev_e             old_sev,
  input  logic [PRI_W-1:0] new_pri,
  input  logic [PRI_W-1:0] old_pri,
  output act_e             act,
  output logic             wr_fields
);

  always_comb begin
    act       = ACT_IGNORE;
    wr_fields = 1'b0;
    if (ev_valid && (new_sev != SEV_NONE)) begin
      if (!rec_live) begin
        act       = ACT_FIRST;
        wr_fields = 1'b1;
      end else if (new_sev > old_sev) begin
        act       = ACT_RAISE;
        wr_fields = 1'b1;
      end else if (new_sev == old_sev) begin
        act       = ACT_SAME;
        wr_fields = (new_pri > old_pri);
      end
    end
  end

endmodule

// File: rtl/err_ce_counter.sv
module err_ce_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
      if (&cnt) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/err_rec_logger.sv
module err_rec_logger
  import err_rec_pkg::*;
#(
  parameter int PRI_W  = 2,
  parameter int CODE_W = 8,
  parameter int AT_W   = 4,
  parameter int CEC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              ev_uue,
  input  logic              ev_ude,
  input  logic              ev_ce,
  input  logic [PRI_W-1:0]  ev_pri,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [AT_W-1:0]   ev_atype,
  input  logic              ev_info_vld,
  input  logic              ev_supp_vld,
  input  logic              ev_ts_vld,
  input  logic              ev_scrub,
  input  logic              ctl_we,
  input  logic              ctl_inval,
  output logic              st_valid,
  output logic              st_uue,
  output logic              st_ude,
  output logic              st_ce,
  output logic              st_mo,
  output logic              st_rdip,
  output logic [PRI_W-1:0]  st_pri,
  output logic [CODE_W-1:0] st_code,
  output logic [AT_W-1:0]   st_atype,
  output logic              st_info_vld,
  output logic              st_supp_vld,
  output logic              st_ts_vld,
  output logic              st_scrub,
  output logic [CEC_W-1:0]  st_cec,
  output logic              st_ceco
);

  logic inval;
  logic live;
  sev_e new_sev;
  sev_e old_sev;
  act_e act;
  logic wr_fields;

  assign inval   = ctl_we & ctl_inval;
  // Invalidate is applied before the incoming report is judged.
  assign live    = st_valid & ~inval;
  assign new_sev = sev_of(ev_uue, ev_ude, ev_ce);
  assign old_sev = sev_of(st_uue, st_ude, st_ce);

  err_rec_decide #(.PRI_W(PRI_W)) u_decide (
    .ev_valid  (ev_valid),
    .rec_live  (live),
    .new_sev   (new_sev),
    .old_sev   (old_sev),
    .new_pri   (ev_pri),
    .old_pri   (st_pri),
    .act       (act),
    .wr_fields (wr_fields)
  );

  err_ce_counter #(.CNT_W(CEC_W)) u_cec (
    .clk (clk),
    .rst (rst),
    .inc (ev_valid & ev_ce),
    .cnt (st_cec),
    .ovf (st_ceco)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid    <= 1'b0;
      st_uue      <= 1'b0;
      st_ude      <= 1'b0;
      st_ce       <= 1'b0;
      st_mo       <= 1'b0;
      st_rdip     <= 1'b0;
      st_pri      <= '0;
      st_code     <= '0;
      st_atype    <= '0;
      st_info_vld <= 1'b0;
      st_supp_vld <= 1'b0;
      st_ts_vld   <= 1'b0;
      st_scrub    <= 1'b0;
    end else begin
      if (inval) st_valid <= 1'b0;
      case (act)
        ACT_FIRST: begin
          st_uue  <= ev_uue;
          st_ude  <= ev_ude & ~ev_uue;
          st_ce   <= ev_ce & ~ev_uue & ~ev_ude;
          st_mo   <= 1'b0;
          st_rdip <= 1'b1;
        end
        ACT_RAISE: begin
          st_uue  <= st_uue | ev_uue;
          st_ude  <= st_ude | ev_ude;
          st_ce   <= st_ce | ev_ce;
          st_rdip <= 1'b0;
        end
        ACT_SAME: begin
          st_mo   <= 1'b1;
          st_rdip <= 1'b0;
        end
        default: ;
      endcase
      if (wr_fields) begin
        st_valid    <= 1'b1;
        st_pri      <= ev_pri;
        st_code     <= ev_code;
        st_atype    <= ev_atype;
        st_info_vld <= ev_info_vld;
        st_supp_vld <= ev_supp_vld;
        st_ts_vld   <= ev_ts_vld;
        st_scrub    <= ev_scrub;
      end
    end
  end

endmodule

// File: rtl/err_rec_logger_chk.sv
module err_rec_logger_chk
  import err_rec_pkg::*;
#(
  parameter int PRI_W  = 2,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic              ev_uue,
  input logic              ev_ude,
  input logic              ev_ce,
  input logic              ctl_we,
  input logic              ctl_inval,
  input logic              st_valid,
  input logic              st_uue,
  input logic              st_ude,
  input logic              st_ce,
  input logic              st_mo,
  input logic              st_rdip,
  input logic [PRI_W-1:0]  st_pri,
  input logic [CODE_W-1:0] st_code,
  input logic              st_ceco
);

  sev_e ns;
  sev_e os;
  logic kill;
  logic rep;

  assign ns   = sev_of(ev_uue, ev_ude, ev_ce);
  assign os   = sev_of(st_uue, st_ude, st_ce);
  assign kill = ctl_we & ctl_inval;
  assign rep  = ev_valid & (ns != SEV_NONE);

  a_r2_quiet_strobe: assert property (@(posedge clk) disable iff (rst)
    (!rep && !kill) |=> ($stable(st_valid) && $stable(st_pri) && $stable(st_code)
                         && $stable(st_mo) && $stable(st_rdip)));

  a_r3_first_log: assert property (@(posedge clk) disable iff (rst)
    (rep && !st_valid) |=> (st_valid && st_rdip && !st_mo));

  a_r4_sticky_raise: assert property (@(posedge clk) disable iff (rst)
    (rep && !kill && st_valid && (ns > os))
      |=> (!st_rdip && (st_ce || !$past(st_ce)) && (st_ude || !$past(st_ude))));

  a_r5_same_sets_mo: assert property (@(posedge clk) disable iff (rst)
    (rep && !kill && st_valid && (ns == os)) |=> (st_mo && !st_rdip));

  a_r6_lower_holds: assert property (@(posedge clk) disable iff (rst)
    (rep && !kill && st_valid && (ns < os))
      |=> ($stable(st_pri) && $stable(st_code) && $stable(st_rdip) && $stable(st_mo)));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    st_ceco |=> st_ceco);

  a_r8_inval_clears: assert property (@(posedge clk) disable iff (rst)
    (kill && !rep) |=> !st_valid);

  a_r9_inval_first: assert property (@(posedge clk) disable iff (rst)
    (kill && rep) |=> (st_valid && st_rdip && !st_mo));

endmodule

bind err_rec_logger err_rec_logger_chk #(.PRI_W(PRI_W), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ev_valid  (ev_valid),
  .ev_uue    (ev_uue),
  .ev_ude    (ev_ude),
  .ev_ce     (ev_ce),
  .ctl_we    (ctl_we),
  .ctl_inval (ctl_inval),
  .st_valid  (st_valid),
  .st_uue    (st_uue),
  .st_ude    (st_ude),
  .st_ce     (st_ce),
  .st_mo     (st_mo),
  .st_rdip   (st_rdip),
  .st_pri    (st_pri),
  .st_code   (st_code),
  .st_ceco   (st_ceco)
);

// File: tb/test_err_rec_logger.sv
`timescale 1ns/1ps
module test_err_rec_logger;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 0, ev_uue = 0, ev_ude = 0, ev_ce = 0;
  logic [1:0] ev_pri = '0;
  logic [7:0] ev_code = '0;
  logic [3:0] ev_atype = '0;
  logic ev_info_vld = 0, ev_supp_vld = 0, ev_ts_vld = 0, ev_scrub = 0;
  logic ctl_we = 0, ctl_inval = 0;
  logic st_valid, st_uue, st_ude, st_ce, st_mo, st_rdip;
  logic [1:0] st_pri;
  logic [7:0] st_code;
  logic [3:0] st_atype;
  logic st_info_vld, st_supp_vld, st_ts_vld, st_scrub;
  logic [3:0] st_cec;
  logic st_ceco;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  err_rec_logger i_err_rec_logger (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_uue(ev_uue), .ev_ude(ev_ude),
    .ev_ce(ev_ce), .ev_pri(ev_pri), .ev_code(ev_code), .ev_atype(ev_atype),
    .ev_info_vld(ev_info_vld), .ev_supp_vld(ev_supp_vld), .ev_ts_vld(ev_ts_vld),
    .ev_scrub(ev_scrub), .ctl_we(ctl_we), .ctl_inval(ctl_inval),
    .st_valid(st_valid), .st_uue(st_uue), .st_ude(st_ude), .st_ce(st_ce),
    .st_mo(st_mo), .st_rdip(st_rdip), .st_pri(st_pri), .st_code(st_code),
    .st_atype(st_atype), .st_info_vld(st_info_vld), .st_supp_vld(st_supp_vld),
    .st_ts_vld(st_ts_vld), .st_scrub(st_scrub), .st_cec(st_cec), .st_ceco(st_ceco)
  );

  logic [28:0] act_vec;
  assign act_vec = {st_valid, st_uue, st_ude, st_ce, st_mo, st_rdip, st_pri, st_code,
                    st_atype, st_info_vld, st_supp_vld, st_ts_vld, st_scrub, st_cec, st_ceco};

  // Scoreboard queues
  logic [28:0] q_exp[$];
  string       q_req[$];

  // Bench model of the record
  logic m_valid = 0, m_uue = 0, m_ude = 0, m_ce = 0, m_mo = 0, m_rdip = 0;
  logic [1:0] m_pri = '0;
  logic [7:0] m_code = '0;
  logic [3:0] m_at = '0;
  logic [3:0] m_fl = '0;
  logic [3:0] m_cec = '0;
  logic m_ceco = 0;

  task automatic drive(input logic v, input logic u, input logic d, input logic c,
                       input logic [1:0] pri, input logic [7:0] code, input logic [3:0] at,
                       input logic [3:0] fl, input logic inv, input string req);
    int ns;
    int os;
    logic live;
    logic wr;
    @(negedge clk);
    ev_valid = v; ev_uue = u; ev_ude = d; ev_ce = c; ev_pri = pri; ev_code = code;
    ev_atype = at; {ev_info_vld, ev_supp_vld, ev_ts_vld, ev_scrub} = fl;
    ctl_we = inv; ctl_inval = inv;
    ns = u ? 3 : d ? 2 : c ? 1 : 0;
    os = m_uue ? 3 : m_ude ? 2 : m_ce ? 1 : 0;
    live = m_valid & ~inv;
    wr = 1'b0;
    if (v && c) begin
      if (m_cec == 4'hF) m_ceco = 1'b1;
      m_cec = m_cec + 4'd1;
    end
    if (inv) m_valid = 1'b0;
    if (v && ns != 0) begin
      if (!live) begin
        m_uue = u; m_ude = d & ~u; m_ce = c & ~u & ~d; m_mo = 0; m_rdip = 1; wr = 1;
      end else if (ns > os) begin
        m_uue = m_uue | u; m_ude = m_ude | d; m_ce = m_ce | c; m_rdip = 0; wr = 1;
      end else if (ns == os) begin
        m_mo = 1; m_rdip = 0; wr = (pri > m_pri);
      end
    end
    if (wr) begin
      m_valid = 1; m_pri = pri; m_code = code; m_at = at; m_fl = fl;
    end
    q_exp.push_back({m_valid, m_uue, m_ude, m_ce, m_mo, m_rdip, m_pri, m_code,
                     m_at, m_fl, m_cec, m_ceco});
    q_req.push_back(req);
  endtask

  // Monitor: compares one cycle after each driven item
  logic [28:0] mon_e;
  string       mon_r;
  always @(posedge clk) begin
    #1;
    if (q_exp.size() != 0) begin
      mon_e = q_exp.pop_front();
      mon_r = q_req.pop_front();
      checks++;
      if (act_vec !== mon_e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", mon_r, act_vec, mon_e);
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (act_vec !== '0) begin
      errors++;
      $display("FAIL R1 reset actual=%h expected=%h", act_vec, 29'h0);
    end
    @(negedge clk);
    rst = 1'b0;
    // R2: strobe with no severity bits is ignored
    drive(1, 0, 0, 0, 2'd3, 8'hAA, 4'h5, 4'hF, 0, "R2 empty strobe");
    // R3: first log
    drive(1, 0, 0, 1, 2'd1, 8'h11, 4'h2, 4'b1010, 0, "R3 first CE");
    drive(0, 0, 0, 0, 2'd0, 8'h00, 4'h0, 4'h0, 0, "R2 idle");
    // R5: equal severity
    drive(1, 0, 0, 1, 2'd0, 8'h22, 4'h3, 4'b0101, 0, "R5 same lower pri");
    drive(1, 0, 0, 1, 2'd1, 8'h33, 4'h4, 4'b0011, 0, "R5 same equal pri");
    drive(1, 0, 0, 1, 2'd3, 8'h44, 4'h6, 4'b1100, 0, "R5 same higher pri");
    // R4: more severe
    drive(1, 0, 1, 0, 2'd0, 8'h55, 4'h7, 4'b0001, 0, "R4 raise to UDE");
    // R6: less severe
    drive(1, 0, 0, 1, 2'd3, 8'h66, 4'h8, 4'b1111, 0, "R6 lower CE counts");
    drive(1, 1, 0, 0, 2'd1, 8'h77, 4'h9, 4'b0110, 0, "R4 raise to UUE");
    drive(1, 0, 1, 0, 2'd3, 8'h88, 4'hA, 4'b1001, 0, "R6 lower UDE");
    // R8: invalidate
    drive(0, 0, 0, 0, 2'd0, 8'h00, 4'h0, 4'h0, 1, "R8 invalidate");
    // R3 with all bits set: masking
    drive(1, 1, 1, 1, 2'd2, 8'h99, 4'hB, 4'b1110, 0, "R3 masked first");
    drive(1, 1, 0, 0, 2'd1, 8'h9A, 4'h1, 4'b0000, 0, "R5 UUE same");
    // R9: invalidate and report together
    drive(1, 0, 1, 0, 2'd0, 8'hBB, 4'hC, 4'b0010, 1, "R9 inval with report");
    drive(1, 0, 1, 0, 2'd0, 8'hBC, 4'hD, 4'b0100, 0, "R5 UDE equal pri");
    // R7: wrap the counter and beyond
    for (int i = 0; i < 20; i++) begin
      drive(1, 0, 0, 1, 2'(i), 8'(i), 4'h0, 4'h0, 0, "R7 counter wrap");
    end
    drive(0, 0, 0, 0, 2'd0, 8'h00, 4'h0, 4'h0, 0, "R7 idle after wrap");
    repeat (3) @(posedge clk);
    #1;
    finish_run();
  end

endmodule